// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

This block picks one of two reference clocks and derives thirteen clock outputs from it, grouped in three banks. Bank A has six copies of one clock, bank B six copies of another, and bank C one output. A four-bit ratio code sets the ratio of all three banks together. One control input does two jobs. While it is high, every divider is held cleared, all data outputs sit low, and the output enables of banks A and B are low, which stands for a high-impedance driver. While it is low, the dividers run and banks A and B are driven.

Each output driver is modelled as a data bit plus an enable bit. Every power-of-two ratio is a tap of a single down-counter clocked by the selected reference. All those outputs therefore share one phase, and each output rises at the start of its period. The divide-by-6 option of bank C comes from a separate modulo-3 toggle stage, which gives an even duty cycle. The ratio code is captured only while the dividers are stopped. Release of the hold is re-timed onto the selected reference, so every output makes its first rising edge on one common reference edge.

Software or board logic should change the reference choice and the ratio code only while the hold input is high. A change made while the dividers run has no effect on the ratio code until the next hold.

Top module: `clkdiv_bank_top`

## Requirements
- R1: `ref_pick` = 0 drives every divider from `clk_ref0`, and `ref_pick` = 1 drives them from `clk_ref1`.
- R2: Bank A takes its ratio from `ratio_code[2:0]`: code 0 gives ÷1, 1 gives ÷2, 2 gives ÷4, 3 gives ÷8, 4 gives ÷16, 5 gives ÷2, 6 gives ÷4 and 7 gives ÷8. At ÷1, bank A follows the selected reference while the dividers run.
- R3: Bank B uses the bank A ratio when `ratio_code[3]` = 0 and twice that ratio when it is 1, so bank B reaches ÷32.
- R4: Bank C takes its ratio from `ratio_code[2:1]`: 00 gives ÷4, 01 gives ÷6, 10 gives ÷8 and 11 gives ÷16.
- R5: At ÷6, bank C stays high for 3 reference cycles and then low for 3.
- R6: While `halt_hiz` is high, `bank_a_oe` and `bank_b_oe` are 0 and every data output is 0. While it is low, both enables are 1.
- R7: After `halt_hiz` falls, all outputs stay low until the third rising edge of the selected reference. On that edge every output rises.
- R8: Counting that common edge as edge 1, each divided output of ratio N is high after edges 1 to N/2 and low after edges N/2+1 to N, and it repeats every N edges.
- R9: The ratio code in force is the one present at the last reference edge before the dividers start. Any later change to `ratio_code` has no effect until the next hold.
- R10: All six outputs of bank A carry the same value, and so do all six outputs of bank B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref0 | input | 1 | Reference clock, used when `ref_pick` is 0 |
| clk_ref1 | input | 1 | Reference clock, used when `ref_pick` is 1 |
| ref_pick | input | 1 | Reference choice |
| ratio_code | input | 4 | Ratio code for all banks |
| halt_hiz | input | 1 | High: clear dividers and disable banks A and B |
| bank_a_q | output | 6 | Bank A clock outputs |
| bank_a_oe | output | 1 | Bank A driver enable |
| bank_b_q | output | 6 | Bank B clock outputs |
| bank_b_oe | output | 1 | Bank B driver enable |
| bank_c_q | output | 1 | Bank C clock output |

## Verification
The bench goes after the start-up edge. A release that is not re-timed would start the outputs one edge too early. A plain up-counter would make the slow outputs rise late or start high. Either fault shows as a mismatch on the first few samples after the hold drops. It also runs ÷32 on bank B and ÷6 on bank C. A wrong extra halving or a modulo-6 counter with an off-by-one gives the wrong period or an uneven duty cycle. It changes the ratio code while the dividers run. A design that re-reads the code at once switches ratio in the middle of a period and drifts away from the model. It also runs one pass on the second reference, at a different period, to catch an inverted reference choice.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    C_DIV4  = 2'd0,
    C_DIV6  = 2'd1,
    C_DIV8  = 2'd2,
    C_DIV16 = 2'd3
  } c_mode_t;

  typedef struct packed {
    logic [2:0] a_exp;   // log2 of bank A ratio, 0 means pass-through
    logic [2:0] b_exp;   // log2 of bank B ratio
    c_mode_t    c_mode;
  } ratio_cfg_t;

  function automatic ratio_cfg_t decode_ratio(input logic [CODE_W-1:0] code);
    ratio_cfg_t r;
    case (code[2:0])
      3'd5:    r.a_exp = 3'd1;
      3'd6:    r.a_exp = 3'd2;
      3'd7:    r.a_exp = 3'd3;
      default: r.a_exp = code[2:0];
    endcase
    r.b_exp  = r.a_exp + {2'b00, code[3]};
    r.c_mode = c_mode_t'(code[2:1]);
    return r;
  endfunction

endpackage

// File: rtl/cdiv_ref_mux.sv
module cdiv_ref_mux (
  input  logic clk_in0,
  input  logic clk_in1,
  input  logic pick,
  output logic clk_out
);
  // Glitches are harmless: the choice only moves while the dividers are held.
  assign clk_out = pick ? clk_in1 : clk_in0;
endmodule

// File: rtl/cdiv_release.sv
module cdiv_release #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic hold,
  output logic run,
  output logic live
);
  logic [SYNC_STAGES:0] stage_q;

  always_ff @(posedge clk or posedge hold) begin
    if (hold) stage_q <= '0;
    else      stage_q <= {stage_q[SYNC_STAGES-1:0], 1'b1};
  end

  assign run  = stage_q[SYNC_STAGES-1];
  assign live = stage_q[SYNC_STAGES];
endmodule

// File: rtl/cdiv_pow2_chain.sv
module cdiv_pow2_chain #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             run,
  output logic [CNT_W-1:0] taps
);
  // Down-counter: on the first counting edge every bit goes high together.
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge hold) begin
    if (hold)     cnt_q <= '0;
    else if (run) cnt_q <= cnt_q - 1'b1;
  end

  assign taps = cnt_q;
endmodule

// File: rtl/cdiv_toggle_mod.sv
module cdiv_toggle_mod #(
  parameter int HALF = 3
) (
  input  logic clk,
  input  logic hold,
  input  logic run,
  output logic q
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic [PW-1:0] ph_q;
  logic          q_q;

  always_ff @(posedge clk or posedge hold) begin
    if (hold) begin
      ph_q <= '0;
      q_q  <= 1'b0;
    end else if (run) begin
      if (ph_q == '0) q_q <= ~q_q;
      ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/clkdiv_bank_top.sv
module clkdiv_bank_top
  import clkdiv_pkg::*;
#(
  parameter int NUM_A       = 6,
  parameter int NUM_B       = 6,
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int C_ODD_HALF  = 3
) (
  input  logic                clk_ref0,
  input  logic                clk_ref1,
  input  logic                ref_pick,
  input  logic [CODE_W-1:0]   ratio_code,
  input  logic                halt_hiz,
  output logic [NUM_A-1:0]    bank_a_q,
  output logic                bank_a_oe,
  output logic [NUM_B-1:0]    bank_b_q,
  output logic                bank_b_oe,
  output logic                bank_c_q
);

  logic             ref_clk;
  logic             run;
  logic             live;
  logic [CNT_W-1:0] taps;
  logic             odd_q;
  logic [CODE_W-1:0] cfg_q;
  ratio_cfg_t       cfg;
  logic             a_clk;
  logic             b_clk;
  logic             c_clk;

  cdiv_ref_mux u_mux (
    .clk_in0 (clk_ref0),
    .clk_in1 (clk_ref1),
    .pick    (ref_pick),
    .clk_out (ref_clk)
  );

  cdiv_release #(.SYNC_STAGES(SYNC_STAGES)) u_rel (
    .clk  (ref_clk),
    .hold (halt_hiz),
    .run  (run),
    .live (live)
  );

  cdiv_pow2_chain #(.CNT_W(CNT_W)) u_chain (
    .clk  (ref_clk),
    .hold (halt_hiz),
    .run  (run),
    .taps (taps)
  );

  cdiv_toggle_mod #(.HALF(C_ODD_HALF)) u_odd (
    .clk  (ref_clk),
    .hold (halt_hiz),
    .run  (run),
    .q    (odd_q)
  );

  // Ratio code follows the input only while the dividers are stopped.
  always_ff @(posedge ref_clk) begin
    if (!run) cfg_q <= ratio_code;
  end

  assign cfg = decode_ratio(cfg_q);

  function automatic logic tap_for(input logic [CNT_W-1:0] t,
                                   input logic [2:0]       e);
    logic v;
    v = 1'b0;
    for (int i = 1; i <= CNT_W; i++) begin
      if (e == 3'(i)) v = t[i-1];
    end
    return v;
  endfunction

  assign a_clk = (cfg.a_exp == 3'd0) ? (ref_clk & live) : tap_for(taps, cfg.a_exp);
  assign b_clk = (cfg.b_exp == 3'd0) ? (ref_clk & live) : tap_for(taps, cfg.b_exp);

  always_comb begin
    case (cfg.c_mode)
      C_DIV4:  c_clk = taps[1];
      C_DIV6:  c_clk = odd_q;
      C_DIV8:  c_clk = taps[2];
      default: c_clk = taps[3];
    endcase
  end

  for (genvar i = 0; i < NUM_A; i++) begin : g_bank_a
    assign bank_a_q[i] = a_clk;
  end
  for (genvar i = 0; i < NUM_B; i++) begin : g_bank_b
    assign bank_b_q[i] = b_clk;
  end

  assign bank_c_q  = c_clk;
  assign bank_a_oe = ~halt_hiz;
  assign bank_b_oe = ~halt_hiz;

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_A = 6,
  parameter int CNT_W = 5
) (
  input logic              ref_clk,
  input logic              halt_hiz,
  input logic              run,
  input logic              live,
  input logic [CNT_W-1:0]  taps,
  input logic [CODE_W-1:0] cfg_q,
  input logic [NUM_A-1:0]  bank_a_q,
  input logic              bank_a_oe,
  input logic              bank_b_oe,
  input logic              bank_c_q
);

  // R9: captured code never moves while the dividers run
  assert_cfg_frozen_R9: assert property (@(posedge ref_clk) disable iff (halt_hiz)
    run |=> $stable(cfg_q));

  // R5: odd mode holds high for three reference edges
  assert_odd_high3_R5: assert property (@(posedge ref_clk) disable iff (halt_hiz)
    (decode_ratio(cfg_q).c_mode == C_DIV6 && $rose(bank_c_q))
      |-> ##1 bank_c_q ##1 bank_c_q ##1 !bank_c_q);

  // R8: fastest tap toggles on every counting edge
  assert_half_rate_R8: assert property (@(posedge ref_clk) disable iff (halt_hiz)
    (live && $past(live)) |-> (taps[0] != $past(taps[0])));

  // R7: on the first live edge every tap and bank C are high together
  assert_common_start_R7: assert property (@(posedge ref_clk) disable iff (halt_hiz)
    (live && !$past(live)) |-> ((&taps) && bank_c_q));

  // R6: a settled hold keeps everything quiet and disabled
  assert_hold_quiet_R6: assert property (@(negedge ref_clk)
    (halt_hiz && $past(halt_hiz)) |->
      (!bank_a_oe && !bank_b_oe && bank_a_q == '0 && !bank_c_q && !run));

endmodule

bind clkdiv_bank_top clkdiv_bank_chk #(.NUM_A(NUM_A), .CNT_W(CNT_W)) u_chk (
  .ref_clk   (ref_clk),
  .halt_hiz  (halt_hiz),
  .run       (run),
  .live      (live),
  .taps      (taps),
  .cfg_q     (cfg_q),
  .bank_a_q  (bank_a_q),
  .bank_a_oe (bank_a_oe),
  .bank_b_oe (bank_b_oe),
  .bank_c_q  (bank_c_q)
);

// File: tb/clkdiv_bank_top_bench.sv
`timescale 1ns/1ps
module clkdiv_bank_top_bench;

  logic       clk0 = 1'b0;
  logic       clk1 = 1'b0;
  logic       pick = 1'b0;
  logic [3:0] code = 4'd0;
  logic       halt = 1'b1;
  logic [5:0] qa;
  logic [5:0] qb;
  logic       oea;
  logic       oeb;
  logic       qc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk0 = ~clk0;   // 100 MHz
  always #8 clk1 = ~clk1;   // second reference, different period

  logic ref_b;
  assign ref_b = pick ? clk1 : clk0;

  clkdiv_bank_top u_clkdiv_bank_top (
    .clk_ref0   (clk0),
    .clk_ref1   (clk1),
    .ref_pick   (pick),
    .ratio_code (code),
    .halt_hiz   (halt),
    .bank_a_q   (qa),
    .bank_a_oe  (oea),
    .bank_b_q   (qb),
    .bank_b_oe  (oeb),
    .bank_c_q   (qc)
  );

  function automatic int ratio_a(input int c);
    case (c % 8)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4: return 16; 5: return 2;  6: return 4;  default: return 8;
    endcase
  endfunction

  function automatic int ratio_b(input int c);
    return (c >= 8) ? 2 * ratio_a(c) : ratio_a(c);
  endfunction

  function automatic int ratio_c(input int c);
    case ((c / 2) % 4)
      0: return 4; 1: return 6; 2: return 8; default: return 16;
    endcase
  endfunction

  // Behavioural level: m counts reference edges since the common start edge.
  function automatic bit level(input int r, input int m, input bit hi);
    if (m < 1)  return 1'b0;
    if (r == 1) return hi;
    return ((m - 1) % r) < (r / 2);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input int c, input int m, input bit hi);
    bit ea, eb, ec;
    ea = level(ratio_a(c), m, hi);
    eb = level(ratio_b(c), m, hi);
    ec = level(ratio_c(c), m, hi);
    // R1 R7 R8 R10 are covered by every one of these comparisons
    check("R2 bank A", int'(qa), ea ? 6'h3f : 6'h00);
    check("R3 bank B", int'(qb), eb ? 6'h3f : 6'h00);
    check((ratio_c(c) == 6) ? "R5 bank C" : "R4 bank C", int'(qc), int'(ec));
    check("R6 enables", int'({oea, oeb}), 2'b11);
  endtask

  // One pass: hold, configure, release, follow the model for n edges.
  task automatic run_pass(input int c, input bit p, input int n, input int chg_at);
    int k;
    halt = 1'b1;
    #1;
    check("R6 oe low on hold", int'({oea, oeb}), 0);
    check("R6 data low on hold", int'({qa, qb, qc}), 0);
    pick = p;
    code = 4'(c);
    repeat (4) @(posedge ref_b);
    #1;
    check("R6 held data", int'({qa, qb, qc}), 0);
    @(negedge ref_b);
    #2 halt = 1'b0;
    k = 0;
    for (int e = 0; e < n; e++) begin
      @(posedge ref_b);
      k++;
      #1 compare_all(c, k - 2, 1'b1);
      // R9: code changes while running must be ignored
      if (k == chg_at) code = ~4'(c);
      @(negedge ref_b);
      #1 compare_all(c, k - 2, 1'b0);
    end
  endtask

  initial begin
    #1;
    check("R6 reset oe", int'({oea, oeb}), 0);
    check("R6 reset data", int'({qa, qb, qc}), 0);
    run_pass(0,  1'b0, 40, 0);   // pass-through A/B, C /4
    run_pass(9,  1'b0, 40, 0);   // A /2, B /4
    run_pass(2,  1'b0, 40, 0);   // A /4, C /6
    run_pass(12, 1'b0, 72, 0);   // A /16, B /32, C /8
    run_pass(7,  1'b0, 40, 10);  // A /8, C /16, code disturbed (R9)
    run_pass(11, 1'b1, 40, 5);   // second reference (R1), B /16, C /6
    run_pass(5,  1'b1, 24, 0);   // A /2, C /8
    run_pass(14, 1'b0, 40, 0);   // A /4, B /8, C /16
    halt = 1'b1;
    #1;
    check("R6 final hold oe", int'({oea, oeb}), 0);
    check("R6 final hold data", int'({qa, qb, qc}), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule